// File: doc/BRIEF.md
# Dual-Space I2C Memory Slave

This block is the serial front end of a memory with two address spaces behind one I2C target. One space is a byte-wide data array. The other is a small bank of clock and control registers. The block samples SCL and SDA with the system clock and finds start and stop conditions. It shifts in the slave byte and decides which space, if any, is addressed. It then either takes a two-byte word address or reuses its internal counter. Acknowledges and read data leave the block as an open-drain pull-down request.

Writes put each data byte at the counter and advance it. Reads return bytes from the counter, most significant bit first, for as long as the master acknowledges. The counter wraps within the size of the space in use. Word-address bits above that size are ignored.

A random read is a dummy write that loads the address, followed by a repeated start with a read slave byte. The block remembers which space the dummy write named. It refuses a read phase that names the other space.

The controller has these states:

- `ST_IDLE`: off the bus.
- `ST_SLAVE_BYTE`: receiving the slave byte. A stop leads to `ST_IDLE` and a start to `ST_SLAVE_BYTE`, from any state.
  - On the falling edge after 8 bits, it goes to `ST_SLAVE_ACK` on a match, or to `ST_IDLE` otherwise.
- `ST_SLAVE_ACK`: goes to `ST_RD_DATA` for a read or to `ST_ADDR_HI` for a write.
- `ST_ADDR_HI`, then `ST_ADDR_HI_ACK`, then `ST_ADDR_LO`, then `ST_ADDR_LO_ACK`: the two word-address bytes, then on to `ST_WR_DATA`.
- `ST_WR_DATA` and `ST_WR_ACK`: alternate for each data byte written.
- `ST_RD_DATA`: goes to `ST_RD_ACK` after 8 bits.
- `ST_RD_ACK`: goes to `ST_RD_DATA` if the master acknowledges, or to `ST_HOLD` if it does not.
- `ST_HOLD`: stays off the bus until the next start or stop.

Top module: `i2c_dual_space_slave`

## Requirements
- R1: A slave byte whose bits 7..1 equal 1010111 addresses the data array, and 1101111 addresses the register space. In either case SDA is pulled low during the ninth SCL pulse.
- R2: Any other value of bits 7..1 is not acknowledged, including a wrong upper nibble or device select bits other than 111. SDA then stays released until the next start.
- R3: Bit 0 of the slave byte selects the direction: 1 reads and 0 writes.
- R4: After a write slave byte, two word-address bytes follow, high byte first, and each is acknowledged. Together they load the counter. Bits above the addressed space's width (ARR_AW or REG_AW) are ignored.
- R5: Each data byte after the word address is stored at the counter and acknowledged. The counter then advances.
- R6: A read returns the byte at the counter, MSB first, and the counter then advances. Reading goes on while the master acknowledges each byte. A current-address read after a stop starts where the counter stands.
- R7: The counter wraps from the last address of the addressed space to 0, both when reading and when writing.
- R8: Reset clears the counter to 0, so a current-address read of the array starts at address 0. Reset leaves stored data intact and releases SDA.
- R9: A random read is a dummy write followed by a repeated start with the same identifier and R/W = 1. It returns data from the loaded address.
- R10: If the read phase after a dummy write names the other space, it is not acknowledged and the block returns to idle.
- R11: A master not-acknowledge after a read byte ends the transfer. SDA stays released until a stop or a new start.
- R12: The two spaces have separate storage. A register write does not change the array.
- R13: A stop returns the block to idle with SDA released. Apart from start and stop, the SDA output changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level, as seen on the wired bus |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench builds the block with ARR_AW = 5 and REG_AW = 3, which gives a 32-byte array and an 8-register space. With these sizes both wrap points are a few bytes from any start address. Word-address bytes such as 0xFF 0xFE then exercise the ignored upper bits, and consecutive bytes cross the end of each space within one short transfer. The same small spaces keep the mismatched random reads and the current-address read after a mid-run reset short.

// File: rtl/i2cds_pkg.sv
package i2cds_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SLAVE_BYTE,
        ST_SLAVE_ACK,
        ST_ADDR_HI,
        ST_ADDR_HI_ACK,
        ST_ADDR_LO,
        ST_ADDR_LO_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_HOLD
    } fsm_state_t;

    typedef enum logic {
        TGT_ARRAY = 1'b0,
        TGT_REGS  = 1'b1
    } target_t;

    localparam logic [3:0] ID_ARRAY   = 4'b1010;
    localparam logic [3:0] ID_REGS    = 4'b1101;
    localparam logic [2:0] DEV_SELECT = 3'b111;

endpackage

// File: rtl/i2cds_bus_sampler.sv
module i2cds_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Idle bus is high on both lines, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // A data edge with the clock held high marks a bus condition.
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cds_ram.sv
module i2cds_ram #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/i2cds_ctrl.sv
module i2cds_ctrl
    import i2cds_pkg::*;
#(
    parameter int ARR_AW = 11,
    parameter int REG_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [7:0]        arr_rdata,
    input  logic [7:0]        reg_rdata,
    output logic              arr_we,
    output logic              reg_we,
    output logic [ARR_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [ARR_AW-1:0] rd_addr,
    output logic              sda_pull,
    output logic [3:0]        bit_cnt_o
);

    localparam logic [ARR_AW-1:0] REG_MASK = ARR_AW'((1 << REG_AW) - 1);

    fsm_state_t        state;
    fsm_state_t        state_nxt;
    logic [3:0]        bit_cnt;
    logic [7:0]        rx_sh;
    logic [7:0]        tx_sh;
    logic [7:0]        addr_hi;
    logic [ARR_AW-1:0] ptr;
    target_t           tgt_q;
    logic              rw_q;
    logic              mack_q;
    logic              pend_valid;
    target_t           pend_tgt;

    logic              byte_done;
    logic              id_ok;
    target_t           tgt_dec;
    logic              mismatch;
    logic              dev_ok;
    logic              rx_state;
    logic              dev_decide;
    logic              alo_done;
    logic              wr_fire;
    logic              rd_last_bit;
    logic [15:0]       word_addr;

    function automatic logic [ARR_AW-1:0] fit_space(input logic [ARR_AW-1:0] a,
                                                    input target_t t);
        return (t == TGT_REGS) ? (a & REG_MASK) : a;
    endfunction

    assign byte_done   = (bit_cnt == 4'd8);
    assign tgt_dec     = (rx_sh[7:4] == ID_REGS) ? TGT_REGS : TGT_ARRAY;
    assign id_ok       = (rx_sh[3:1] == DEV_SELECT) &&
                         ((rx_sh[7:4] == ID_ARRAY) || (rx_sh[7:4] == ID_REGS));
    assign mismatch    = rx_sh[0] && pend_valid && (tgt_dec != pend_tgt);
    assign dev_ok      = id_ok && !mismatch;
    assign rx_state    = (state == ST_SLAVE_BYTE) || (state == ST_ADDR_HI) ||
                         (state == ST_ADDR_LO)    || (state == ST_WR_DATA);
    assign dev_decide  = !stop_det && !start_det && (state == ST_SLAVE_BYTE) &&
                         scl_fall && byte_done;
    assign alo_done    = !stop_det && !start_det && (state == ST_ADDR_LO) &&
                         scl_fall && byte_done;
    assign wr_fire     = !stop_det && !start_det && (state == ST_WR_DATA) &&
                         scl_fall && byte_done;
    assign rd_last_bit = !stop_det && !start_det && (state == ST_RD_DATA) &&
                         scl_fall && (bit_cnt == 4'd7);
    assign word_addr   = {addr_hi, rx_sh};

    // Next-state decision
    always_comb begin
        state_nxt = state;
        if (stop_det) begin
            state_nxt = ST_IDLE;
        end else if (start_det) begin
            state_nxt = ST_SLAVE_BYTE;
        end else begin
            unique case (state)
                ST_IDLE, ST_HOLD: state_nxt = state;
                ST_SLAVE_BYTE:
                    if (scl_fall && byte_done) state_nxt = dev_ok ? ST_SLAVE_ACK : ST_IDLE;
                ST_SLAVE_ACK:
                    if (scl_fall) state_nxt = rw_q ? ST_RD_DATA : ST_ADDR_HI;
                ST_ADDR_HI:
                    if (scl_fall && byte_done) state_nxt = ST_ADDR_HI_ACK;
                ST_ADDR_HI_ACK:
                    if (scl_fall) state_nxt = ST_ADDR_LO;
                ST_ADDR_LO:
                    if (scl_fall && byte_done) state_nxt = ST_ADDR_LO_ACK;
                ST_ADDR_LO_ACK:
                    if (scl_fall) state_nxt = ST_WR_DATA;
                ST_WR_DATA:
                    if (scl_fall && byte_done) state_nxt = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall) state_nxt = ST_WR_DATA;
                ST_RD_DATA:
                    if (scl_fall && bit_cnt == 4'd7) state_nxt = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_fall) state_nxt = mack_q ? ST_RD_DATA : ST_HOLD;
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Shifters, counter and random-read tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '1;
            addr_hi    <= '0;
            ptr        <= '0;
            tgt_q      <= TGT_ARRAY;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            pend_valid <= 1'b0;
            pend_tgt   <= TGT_ARRAY;
            arr_we     <= 1'b0;
            reg_we     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            arr_we <= 1'b0;
            reg_we <= 1'b0;

            if (start_det || state_nxt != state) begin
                bit_cnt <= '0;
            end else if (rx_state && scl_rise && !byte_done) begin
                bit_cnt <= bit_cnt + 4'd1;
            end else if (state == ST_RD_DATA && scl_fall) begin
                bit_cnt <= bit_cnt + 4'd1;
            end

            if (rx_state && scl_rise && !byte_done) begin
                rx_sh <= {rx_sh[6:0], sda_s};
            end

            if (state_nxt == ST_RD_DATA && state != ST_RD_DATA) begin
                tx_sh <= (tgt_q == TGT_REGS) ? reg_rdata : arr_rdata;
            end else if (state == ST_RD_DATA && scl_fall) begin
                tx_sh <= {tx_sh[6:0], 1'b1};
            end

            if (state == ST_RD_ACK && scl_rise) begin
                mack_q <= !sda_s;
            end

            if (dev_decide) begin
                pend_valid <= 1'b0;
                if (dev_ok) begin
                    tgt_q <= tgt_dec;
                    rw_q  <= rx_sh[0];
                end
            end

            if (!stop_det && !start_det && state == ST_ADDR_HI && scl_fall && byte_done) begin
                addr_hi <= rx_sh;
            end

            if (alo_done) begin
                ptr        <= fit_space(word_addr[ARR_AW-1:0], tgt_q);
                pend_valid <= 1'b1;
                pend_tgt   <= tgt_q;
            end

            if (wr_fire) begin
                arr_we     <= (tgt_q == TGT_ARRAY);
                reg_we     <= (tgt_q == TGT_REGS);
                wr_addr    <= ptr;
                wr_data    <= rx_sh;
                ptr        <= fit_space(ptr + 1'b1, tgt_q);
                pend_valid <= 1'b0;
            end

            if (rd_last_bit) begin
                ptr <= fit_space(ptr + 1'b1, tgt_q);
            end

            if (stop_det) begin
                pend_valid <= 1'b0;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_SLAVE_ACK, ST_ADDR_HI_ACK,
            ST_ADDR_LO_ACK, ST_WR_ACK: sda_pull = 1'b1;
            ST_RD_DATA:                sda_pull = ~tx_sh[7];
            default:                   sda_pull = 1'b0;
        endcase
    end

    assign rd_addr   = ptr;
    assign bit_cnt_o = bit_cnt;

endmodule

// File: rtl/i2c_dual_space_slave.sv
module i2c_dual_space_slave #(
    parameter int ARR_AW      = 11,
    parameter int REG_AW      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [7:0]        arr_rdata;
    logic [7:0]        reg_rdata;
    logic              arr_we;
    logic              reg_we;
    logic [ARR_AW-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [ARR_AW-1:0] rd_addr;
    logic [3:0]        bit_cnt;

    i2cds_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cds_ctrl #(.ARR_AW(ARR_AW), .REG_AW(REG_AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .arr_rdata (arr_rdata),
        .reg_rdata (reg_rdata),
        .arr_we    (arr_we),
        .reg_we    (reg_we),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .sda_pull  (sda_pull_o),
        .bit_cnt_o (bit_cnt)
    );

    i2cds_ram #(.AW(ARR_AW)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    i2cds_ram #(.AW(REG_AW)) u_regs (
        .clk   (clk),
        .we    (reg_we),
        .waddr (wr_addr[REG_AW-1:0]),
        .wdata (wr_data),
        .raddr (rd_addr[REG_AW-1:0]),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/i2cds_checker.sv
module i2cds_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_pull,
    input logic       arr_we,
    input logic       reg_we,
    input logic [3:0] bit_cnt
);

    assert_stop_releases_R13: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    assert_sda_moves_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

    assert_one_space_written_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_we, reg_we}));

    assert_write_follows_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we || reg_we) |-> $past(scl_fall));

    assert_bit_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

endmodule

bind i2c_dual_space_slave i2cds_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull_o),
    .arr_we    (arr_we),
    .reg_we    (reg_we),
    .bit_cnt   (bit_cnt)
);

// File: tb/test_i2c_dual_space_slave.sv
module test_i2c_dual_space_slave;

    localparam int ARR_AW = 5;
    localparam int REG_AW = 3;
    localparam int QTR    = 4;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_item_t;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic sda_bus;

    exp_item_t  exp_q[$];
    int         n_checks = 0;
    int         n_fail   = 0;
    logic [7:0] obs_val;
    event       obs_ev;
    logic       done = 1'b0;

    assign sda_bus = m_sda & ~sda_pull;

    always #2 clk = ~clk;

    i2c_dual_space_slave #(.ARR_AW(ARR_AW), .REG_AW(REG_AW)) i_i2c_dual_space_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull)
    );

    // Scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected item: actual %h expected none", obs_val);
            end else begin
                exp_item_t e;
                e = exp_q.pop_front();
                if (obs_val !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", e.tag, obs_val, e.val);
                end
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    task automatic quarter();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic expect_item(input logic [7:0] v, input string tag);
        exp_q.push_back('{val: v, tag: tag});
    endtask

    task automatic observe(input logic [7:0] v);
        obs_val = v;
        ->obs_ev;
        @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; quarter();
        scl   = 1'b1; quarter();
        m_sda = 1'b0; quarter();
        scl   = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; quarter();
        scl   = 1'b1; quarter();
        m_sda = 1'b1; quarter();
        quarter();
    endtask

    task automatic clock_bit(input logic b, output logic s);
        m_sda = b; quarter();
        scl   = 1'b1; quarter();
        s     = sda_bus; quarter();
        scl   = 1'b0; quarter();
    endtask

    // Sends a byte; the observed item is the ninth-bit level (0 = acknowledged)
    task automatic send_byte(input logic [7:0] b, input logic exp_nack, input string tag);
        logic s;
        expect_item({7'd0, exp_nack}, tag);
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        observe({7'd0, s});
    endtask

    task automatic recv_byte(input logic [7:0] exp_v, input logic m_ack, input string tag);
        logic       s;
        logic [7:0] v;
        expect_item(exp_v, tag);
        v = '0;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, s);
            v = {v[6:0], s};
        end
        clock_bit(!m_ack, s);
        observe(v);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        quarter();
        expect_item(8'h00, "R8 SDA released after reset");
        observe({7'd0, sda_pull});

        // Array write across the end of the space, upper address bits ignored
        bus_start();
        send_byte(8'hAE, 1'b0, "R1 array identifier acknowledged");
        send_byte(8'hFF, 1'b0, "R4 high address byte acknowledged");
        send_byte(8'hFE, 1'b0, "R4 low address byte acknowledged");
        send_byte(8'h11, 1'b0, "R5 data byte at 30 acknowledged");
        send_byte(8'h22, 1'b0, "R5 data byte at 31 acknowledged");
        send_byte(8'h33, 1'b0, "R7 data byte wrapped to 0 acknowledged");
        bus_stop();
        expect_item(8'h00, "R13 SDA released after stop");
        observe({7'd0, sda_pull});

        // Random read of the array, wrap while reading, master NACK
        bus_start();
        send_byte(8'hAE, 1'b0, "R9 dummy write identifier");
        send_byte(8'h00, 1'b0, "R9 address high");
        send_byte(8'h1E, 1'b0, "R9 address low");
        bus_start();
        send_byte(8'hAF, 1'b0, "R3 read identifier acknowledged");
        recv_byte(8'h11, 1'b1, "R9 random read byte at 30");
        recv_byte(8'h22, 1'b1, "R6 sequential byte at 31");
        recv_byte(8'h33, 1'b0, "R7 read wrapped to address 0");
        recv_byte(8'hFF, 1'b0, "R11 SDA released after master NACK");
        bus_stop();

        // Write address 1, then load address 0 and stop; current-address read follows
        bus_start();
        send_byte(8'hAE, 1'b0, "R3 write direction");
        send_byte(8'h00, 1'b0, "R4 address high");
        send_byte(8'h01, 1'b0, "R4 address low");
        send_byte(8'h44, 1'b0, "R5 data byte at 1");
        bus_stop();
        bus_start();
        send_byte(8'hAE, 1'b0, "R4 load address only");
        send_byte(8'h00, 1'b0, "R4 address high");
        send_byte(8'h00, 1'b0, "R4 address low");
        bus_stop();
        bus_start();
        send_byte(8'hAF, 1'b0, "R6 current read identifier");
        recv_byte(8'h33, 1'b1, "R6 current-address byte at 0");
        recv_byte(8'h44, 1'b0, "R6 current-address byte at 1");
        bus_stop();

        // Register space write with wrap at 8, upper bits ignored
        bus_start();
        send_byte(8'hDE, 1'b0, "R1 register identifier acknowledged");
        send_byte(8'h12, 1'b0, "R4 register address high");
        send_byte(8'h37, 1'b0, "R4 register address low masked to 7");
        send_byte(8'hA1, 1'b0, "R5 register 7 written");
        send_byte(8'hB2, 1'b0, "R7 register wrapped to 0");
        bus_stop();
        bus_start();
        send_byte(8'hDE, 1'b0, "R9 register dummy write");
        send_byte(8'h00, 1'b0, "R9 register address high");
        send_byte(8'h07, 1'b0, "R9 register address low");
        bus_start();
        send_byte(8'hDF, 1'b0, "R9 register read identifier");
        recv_byte(8'hA1, 1'b1, "R9 register 7 readback");
        recv_byte(8'hB2, 1'b0, "R7 register 0 after wrap");
        bus_stop();

        // Array untouched by register writes
        bus_start();
        send_byte(8'hAE, 1'b0, "R12 array dummy write");
        send_byte(8'h00, 1'b0, "R12 address high");
        send_byte(8'h00, 1'b0, "R12 address low");
        bus_start();
        send_byte(8'hAF, 1'b0, "R12 array read identifier");
        recv_byte(8'h33, 1'b1, "R12 array byte 0 unchanged");
        recv_byte(8'h44, 1'b0, "R12 array byte 1 unchanged");
        bus_stop();

        // Mismatched random reads
        bus_start();
        send_byte(8'hAE, 1'b0, "R10 array dummy write");
        send_byte(8'h00, 1'b0, "R10 address high");
        send_byte(8'h00, 1'b0, "R10 address low");
        bus_start();
        send_byte(8'hDF, 1'b1, "R10 register read after array dummy refused");
        recv_byte(8'hFF, 1'b0, "R10 idle after refusal");
        bus_stop();
        bus_start();
        send_byte(8'hDE, 1'b0, "R10 register dummy write");
        send_byte(8'h00, 1'b0, "R10 address high");
        send_byte(8'h02, 1'b0, "R10 address low");
        bus_start();
        send_byte(8'hAF, 1'b1, "R10 array read after register dummy refused");
        bus_stop();

        // Wrong identifiers
        bus_start();
        send_byte(8'hA0, 1'b1, "R2 wrong device select refused");
        send_byte(8'h00, 1'b1, "R2 slave stays off the bus");
        bus_stop();
        bus_start();
        send_byte(8'h5E, 1'b1, "R2 unknown identifier refused");
        bus_stop();
        bus_start();
        send_byte(8'hDC, 1'b1, "R2 register identifier with bad select refused");
        bus_stop();

        // Reset clears the counter but not the storage
        bus_start();
        send_byte(8'hAE, 1'b0, "R8 write before reset");
        send_byte(8'h00, 1'b0, "R8 address high");
        send_byte(8'h00, 1'b0, "R8 address low");
        send_byte(8'h5A, 1'b0, "R8 data at 0");
        send_byte(8'h6B, 1'b0, "R8 data at 1");
        bus_stop();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        quarter();
        bus_start();
        send_byte(8'hAF, 1'b0, "R8 read after reset");
        recv_byte(8'h5A, 1'b1, "R8 current-address read starts at 0");
        recv_byte(8'h6B, 1'b0, "R6 next byte after reset read");
        bus_stop();

        quarter();
        done = 1'b1;
        report();
    end

endmodule